// File: doc/BRIEF.md
# Memory Transaction Identifier Manager

This block hands out identifiers from a pool of 64 for split-phase memory prepare operations and tracks each one through its life. A requester asks for an identifier and receives, in the same cycle, either the lowest-numbered identifier that is not reserved or an overflow indication when the pool is exhausted. A fill engine reports the identifier of each finished fill, and software releases identifiers one at a time or all at once.

Each identifier holds one of four states: free, waiting (fill outstanding), ready (fill done) and held (released early, fill still in flight). A held identifier stays out of the pool until its fill arrives, so a late fill can never be credited to a newer owner. The ready bits of all identifiers form a completion vector that can be read but has no write path.

Top module: `mtid_pool`

## Requirements
- R1: After reset every identifier is free and the completion vector `readyVec` is all zeros.
- R2: While `allocReq` is high and `clearAll` is low, if any identifier is free, `allocGrant` is 1 and `allocId` is the lowest-numbered free identifier in that same cycle; the identifier becomes waiting at the next edge and its `readyVec` bit is 0.
- R3: While `allocReq` is high, `clearAll` is low and no identifier is free, `allocOverflow` is 1, `allocGrant` is 0 and no state changes.
- R4: A fill (`fillValid`) naming a waiting identifier makes it ready; its `readyVec` bit reads 1 from the next cycle.
- R5: Freeing (`freeReq`) a ready identifier returns it to free, clears its `readyVec` bit, and makes it allocatable again.
- R6: Freeing a waiting identifier makes it held: it is not allocated, and a later fill for it returns it to free without setting its `readyVec` bit.
- R7: A fill naming a free or ready identifier has no effect.
- R8: `clearAll` sends every ready identifier to free and every waiting identifier to held; `readyVec` is all zeros on the next cycle.
- R9: In a cycle with `clearAll` high, no allocation takes place: `allocGrant` and `allocOverflow` are both 0.
- R10: When a fill and a free name the same waiting identifier in one cycle, the fill is applied first, so the identifier ends free with `readyVec` bit 0.
- R11: Freeing a free or held identifier has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocReq | input | 1 | Request an identifier this cycle |
| allocGrant | output | 1 | An identifier was granted this cycle |
| allocId | output | 6 | Granted identifier (valid with allocGrant) |
| allocOverflow | output | 1 | Request refused: pool exhausted |
| fillValid | input | 1 | A fill has completed |
| fillId | input | 6 | Identifier of the completed fill |
| freeReq | input | 1 | Release one identifier |
| freeId | input | 6 | Identifier to release |
| clearAll | input | 1 | Release every identifier |
| readyVec | output | 64 | Completion vector, one bit per identifier |

## Verification
The assertions check on every cycle that a grant always names the lowest unreserved identifier, that overflow occurs only on a request against a full pool and never together with a grant, that no completion bit is set for an unreserved identifier, and that a clear or a release of a ready identifier leaves the expected bits at zero. The held state can only be shown by the bench's scenarios: that an early-released identifier is skipped by later allocations, that its late fill frees it silently, and that same-cycle fill-and-free resolves in fill-first order. Ignored fills and frees are likewise shown by following them with allocations and reads of the completion vector.

// File: rtl/mtid_pkg.sv
package mtid_pkg;

  localparam int unsigned POOL_SIZE = 64;

  typedef enum logic [1:0] {
    ID_FREE    = 2'd0,
    ID_WAITING = 2'd1,
    ID_READY   = 2'd2,
    ID_HELD    = 2'd3
  } idState_e;

  // Strobes from control to datapath; indices travel on separate buses.
  typedef struct packed {
    logic allocFire;
    logic fillFire;
    logic freeFire;
    logic clearFire;
  } poolStrobes_t;

  // Per-identifier transition: fill first, then release/clear, then allocate.
  function automatic idState_e nextIdState(
      input idState_e cur,
      input logic     allocHit,
      input logic     fillHit,
      input logic     releaseHit
  );
    idState_e s;
    s = cur;
    if (fillHit) begin
      case (s)
        ID_WAITING: s = ID_READY;
        ID_HELD:    s = ID_FREE;
        default:    s = s;
      endcase
    end
    if (releaseHit) begin
      case (s)
        ID_WAITING: s = ID_HELD;
        ID_READY:   s = ID_FREE;
        default:    s = s;
      endcase
    end
    if (allocHit && s == ID_FREE) begin
      s = ID_WAITING;
    end
    return s;
  endfunction

endpackage

// File: rtl/mtid_ctrl.sv
module mtid_ctrl
  import mtid_pkg::*;
#(
  parameter int unsigned NUM_IDS = POOL_SIZE,
  parameter int unsigned ID_W    = $clog2(NUM_IDS)
) (
  input  logic               allocReq,
  input  logic               fillValid,
  input  logic               freeReq,
  input  logic               clearAll,
  input  logic [NUM_IDS-1:0] reservedVec,
  output poolStrobes_t       strobes,
  output logic               allocGrant,
  output logic [ID_W-1:0]    allocId,
  output logic               allocOverflow
);

  logic            foundAny;
  logic [ID_W-1:0] foundIdx;

  // Lowest-index free identifier: scan downward so the last hit wins.
  always_comb begin
    foundAny = 1'b0;
    foundIdx = '0;
    for (int i = NUM_IDS - 1; i >= 0; i--) begin
      if (!reservedVec[i]) begin
        foundAny = 1'b1;
        foundIdx = ID_W'(i);
      end
    end
  end

  logic allocAllowed;
  assign allocAllowed = allocReq && !clearAll;

  assign allocGrant    = allocAllowed && foundAny;
  assign allocOverflow = allocAllowed && !foundAny;
  assign allocId       = foundIdx;

  always_comb begin
    strobes.allocFire = allocGrant;
    strobes.fillFire  = fillValid;
    strobes.freeFire  = freeReq;
    strobes.clearFire = clearAll;
  end

endmodule

// File: rtl/mtid_datapath.sv
module mtid_datapath
  import mtid_pkg::*;
#(
  parameter int unsigned NUM_IDS = POOL_SIZE,
  parameter int unsigned ID_W    = $clog2(NUM_IDS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  poolStrobes_t       strobes,
  input  logic [ID_W-1:0]    allocIdx,
  input  logic [ID_W-1:0]    fillIdx,
  input  logic [ID_W-1:0]    freeIdx,
  output logic [NUM_IDS-1:0] reservedVec,
  output logic [NUM_IDS-1:0] readyVec
);

  idState_e idState [NUM_IDS];

  for (genvar g = 0; g < NUM_IDS; g++) begin : gSlot
    logic     allocHit;
    logic     fillHit;
    logic     releaseHit;
    idState_e stateNext;

    assign allocHit   = strobes.allocFire && (allocIdx == ID_W'(g));
    assign fillHit    = strobes.fillFire  && (fillIdx  == ID_W'(g));
    assign releaseHit = strobes.clearFire ||
                        (strobes.freeFire && (freeIdx == ID_W'(g)));

    always_comb begin
      stateNext = nextIdState(idState[g], allocHit, fillHit, releaseHit);
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        idState[g]  <= ID_FREE;
        readyVec[g] <= 1'b0;
      end else begin
        idState[g]  <= stateNext;
        readyVec[g] <= (stateNext == ID_READY);
      end
    end

    assign reservedVec[g] = (idState[g] != ID_FREE);
  end

endmodule

// File: rtl/mtid_pool.sv
module mtid_pool
  import mtid_pkg::*;
#(
  parameter int unsigned NUM_IDS = POOL_SIZE,
  parameter int unsigned ID_W    = $clog2(NUM_IDS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               allocReq,
  output logic               allocGrant,
  output logic [ID_W-1:0]    allocId,
  output logic               allocOverflow,
  input  logic               fillValid,
  input  logic [ID_W-1:0]    fillId,
  input  logic               freeReq,
  input  logic [ID_W-1:0]    freeId,
  input  logic               clearAll,
  output logic [NUM_IDS-1:0] readyVec
);

  poolStrobes_t       strobes;
  logic [NUM_IDS-1:0] reservedVec;

  mtid_ctrl #(.NUM_IDS(NUM_IDS), .ID_W(ID_W)) u_ctrl (
    .allocReq      (allocReq),
    .fillValid     (fillValid),
    .freeReq       (freeReq),
    .clearAll      (clearAll),
    .reservedVec   (reservedVec),
    .strobes       (strobes),
    .allocGrant    (allocGrant),
    .allocId       (allocId),
    .allocOverflow (allocOverflow)
  );

  mtid_datapath #(.NUM_IDS(NUM_IDS), .ID_W(ID_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .allocIdx    (allocId),
    .fillIdx     (fillId),
    .freeIdx     (freeId),
    .reservedVec (reservedVec),
    .readyVec    (readyVec)
  );

endmodule

// File: rtl/mtid_pool_checker.sv
module mtid_pool_checker #(
  parameter int unsigned NUM_IDS = 64,
  parameter int unsigned ID_W    = $clog2(NUM_IDS)
) (
  input logic               clk,
  input logic               rstN,
  input logic               allocReq,
  input logic               allocGrant,
  input logic [ID_W-1:0]    allocId,
  input logic               allocOverflow,
  input logic               freeReq,
  input logic [ID_W-1:0]    freeId,
  input logic               clearAll,
  input logic [NUM_IDS-1:0] reservedVec,
  input logic [NUM_IDS-1:0] readyVec
);

  localparam logic [NUM_IDS-1:0] ONE = NUM_IDS'(1);

  logic [NUM_IDS-1:0] belowMask;
  assign belowMask = (ONE << allocId) - ONE;

  assert_lowest_free_R2: assert property (@(posedge clk) disable iff (!rstN)
    allocGrant |-> (!reservedVec[allocId] && ((~reservedVec & belowMask) == '0)));

  assert_alloc_not_ready_R2: assert property (@(posedge clk) disable iff (!rstN)
    allocGrant |=> !readyVec[$past(allocId)]);

  assert_no_overflow_with_grant_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(allocGrant && allocOverflow));

  assert_overflow_only_full_R3: assert property (@(posedge clk) disable iff (!rstN)
    allocOverflow |-> (allocReq && (&reservedVec)));

  assert_ready_is_reserved_R4: assert property (@(posedge clk) disable iff (!rstN)
    (readyVec & ~reservedVec) == '0);

  assert_free_ready_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    (freeReq && readyVec[freeId]) |=> !readyVec[$past(freeId)]);

  assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rstN)
    clearAll |=> (readyVec == '0));

  assert_no_alloc_in_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    clearAll |-> (!allocGrant && !allocOverflow));

endmodule

bind mtid_pool mtid_pool_checker #(.NUM_IDS(NUM_IDS), .ID_W(ID_W)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .allocReq      (allocReq),
  .allocGrant    (allocGrant),
  .allocId       (allocId),
  .allocOverflow (allocOverflow),
  .freeReq       (freeReq),
  .freeId        (freeId),
  .clearAll      (clearAll),
  .reservedVec   (reservedVec),
  .readyVec      (readyVec)
);

// File: tb/mtid_pool_tb.sv
module mtid_pool_tb;

  localparam int unsigned N  = 64;
  localparam int unsigned IW = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          allocReq = 1'b0;
  logic          allocGrant;
  logic [IW-1:0] allocId;
  logic          allocOverflow;
  logic          fillValid = 1'b0;
  logic [IW-1:0] fillId = '0;
  logic          freeReq = 1'b0;
  logic [IW-1:0] freeId = '0;
  logic          clearAll = 1'b0;
  logic [N-1:0]  readyVec;

  int testCount = 0;
  int failCount = 0;

  always #5 clk = ~clk;

  mtid_pool u_dut (
    .clk(clk), .rstN(rstN),
    .allocReq(allocReq), .allocGrant(allocGrant), .allocId(allocId),
    .allocOverflow(allocOverflow),
    .fillValid(fillValid), .fillId(fillId),
    .freeReq(freeReq), .freeId(freeId),
    .clearAll(clearAll), .readyVec(readyVec)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic applyReset();
    @(negedge clk);
    rstN = 1'b0;
    allocReq = 0; fillValid = 0; freeReq = 0; clearAll = 0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  // One allocation cycle; combinational result captured mid-cycle.
  task automatic doAlloc(output logic g, output logic [IW-1:0] id, output logic ov);
    allocReq = 1'b1;
    #1;
    g = allocGrant; id = allocId; ov = allocOverflow;
    @(negedge clk);
    allocReq = 1'b0;
  endtask

  task automatic expectAlloc(input string req, input int expId);
    logic g, ov;
    logic [IW-1:0] id;
    doAlloc(g, id, ov);
    check(req, {62'd0, g, ov}, 64'd2);
    check(req, 64'(id), 64'(expId));
  endtask

  task automatic doFill(input int id);
    fillValid = 1'b1; fillId = IW'(id);
    @(negedge clk);
    fillValid = 1'b0;
  endtask

  task automatic doFree(input int id);
    freeReq = 1'b1; freeId = IW'(id);
    @(negedge clk);
    freeReq = 1'b0;
  endtask

  task automatic testReset();
    applyReset();
    check("R1 readyVec zero", readyVec, 64'd0);
    expectAlloc("R1 first id", 0);
  endtask

  task automatic testAllocFillFree();
    expectAlloc("R2 order", 1);
    expectAlloc("R2 order", 2);
    expectAlloc("R2 order", 3);
    check("R2 ready clear after alloc", readyVec, 64'd0);
    doFill(2);
    check("R4 fill sets ready", readyVec, 64'h4);
    doFill(2);
    check("R7 fill on ready ignored", readyVec, 64'h4);
    doFree(2);
    check("R5 free clears ready", readyVec, 64'd0);
    expectAlloc("R5 reuse freed id", 2);
  endtask

  task automatic testHeld();
    doFree(1);
    check("R6 held not ready", readyVec, 64'd0);
    expectAlloc("R6 held skipped", 4);
    doFree(1);
    check("R11 free of held ignored", readyVec, 64'd0);
    expectAlloc("R11 held still skipped", 5);
    doFill(1);
    check("R6 late fill no ready", readyVec, 64'd0);
    expectAlloc("R6 held back to free", 1);
    doFill(6);
    check("R7 fill on free ignored", readyVec, 64'd0);
    doFree(6);
    expectAlloc("R7 R11 free id unaffected", 6);
  endtask

  task automatic testFillFreeSame();
    fillValid = 1'b1; fillId = 6'd0;
    freeReq = 1'b1; freeId = 6'd0;
    @(negedge clk);
    fillValid = 1'b0; freeReq = 1'b0;
    check("R10 ends not ready", readyVec, 64'd0);
    expectAlloc("R10 ends free", 0);
  endtask

  task automatic testClear();
    logic g, ov;
    logic [IW-1:0] id;
    doFill(3);
    check("R4 id3 ready", readyVec, 64'h8);
    clearAll = 1'b1;
    allocReq = 1'b1;
    #1;
    check("R9 no grant during clear", {63'd0, allocGrant}, 64'd0);
    check("R9 no overflow during clear", {63'd0, allocOverflow}, 64'd0);
    @(negedge clk);
    clearAll = 1'b0; allocReq = 1'b0;
    check("R8 clear empties ready", readyVec, 64'd0);
    expectAlloc("R8 ready id freed", 3);
    expectAlloc("R8 waiting ids held", 7);
    doFill(5);
    check("R8 held late fill no ready", readyVec, 64'd0);
    expectAlloc("R8 held freed by fill", 5);
    doAlloc(g, id, ov);
    check("R8 next free id", 64'(id), 64'd8);
  endtask

  task automatic testOverflow();
    logic g, ov;
    logic [IW-1:0] id;
    applyReset();
    for (int i = 0; i < N; i++) begin
      doAlloc(g, id, ov);
      if (i == 0 || i == N - 1) check("R2 fill pool", 64'(id), 64'(i));
    end
    doAlloc(g, id, ov);
    check("R3 overflow flag", {62'd0, g, ov}, 64'd1);
    check("R3 ready unchanged", readyVec, 64'd0);
    doFill(10);
    check("R4 id10 ready", readyVec, 64'h400);
    doFree(10);
    expectAlloc("R3 R5 freed id after overflow", 10);
  endtask

  initial begin
    #1_000_000;
    failCount++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    testReset();
    testAllocFillFree();
    testHeld();
    testFillFreeSame();
    testClear();
    testOverflow();
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule